// File: doc/BRIEF.md
# Cache Way Victim Selector

This block decides which of the four ways of a set-associative cache takes the next line fill after a miss. The cache controller raises a fill strobe when it needs a way. It also presents a mode bit that picks rotating or pseudo-random replacement, and the 32-bit lockdown word. The way index appears on the output in the same cycle as the strobe. Both replacement engines step at the clock edge that ends that cycle.

Rotating replacement keeps a two-bit counter. On each fill the counter moves to its next value, and that new value is the victim. Random replacement keeps a 32-bit state that follows a multiply-and-xor recurrence, with constant products built from shifts and adds. The victim is taken from two bits of the new state. After the base choice is made, the lockdown word is applied in one of two ways. With the lock flag set, the fill goes to the way the word names. With the flag clear, the word's low bits are ORed into the base choice, so that no fill can land in a way below that floor. Tag storage, hit detection and the line data path sit outside this block.

Top module: `cache_victim_sel`

## Requirements
- R1: A synchronous active-high reset clears the rotating counter to 0 and loads the random state with 44203. The first rotating fill after reset therefore yields way 1, and the first random fill yields bits [18:17] of the first step from 44203.
- R2: On a fill with `rr_mode`=1, the counter first moves to (counter+1) mod 4, and that new value is the base victim. The sequence from reset is 1,2,3,0,1,...
- R3: On a fill with `rr_mode`=0, the random state s becomes s XOR (s*17) XOR (s*7), computed modulo 2^32. The base victim is bits [18:17] of the new state.
- R4: When `lock_reg` bit 31 is 1, `victim_way` equals `lock_reg[1:0]`, whatever the base victim is.
- R5: When `lock_reg` bit 31 is 0, `victim_way` equals the base victim ORed with `lock_reg[1:0]`.
- R6: The counter steps only on a fill in rotating mode, and the random state steps only on a fill in random mode. Neither changes in a cycle without a fill.
- R7: `victim_way` is valid during the same cycle that `fill_req` is high, with no extra cycle of latency.
- R8: Bits [30:2] of `lock_reg` have no effect on the victim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fill_req | input | 1 | Line fill needs a victim this cycle |
| rr_mode | input | 1 | 1 = rotating replacement, 0 = pseudo-random |
| lock_reg | input | 32 | Lockdown word: bit 31 forces the way, bits [1:0] give the way or the floor |
| victim_way | output | 2 | Way chosen for the fill |

## Verification
Long runs of random-mode fills with the lockdown word at zero expose the raw recurrence bits. Any error in the shift-and-add products or in the bit selection shows up within a few fills. Rotating runs with idle gaps, and mode changes made while no fill is pending, separate an engine that steps only on its own fills from one that steps every cycle or in both modes. Lockdown words with random upper bits and the flag both set and clear tell the forced path from the OR-floor path. Fresh resets followed by a single fill in each mode pin down the seed and the initial counter.

// File: rtl/vsel_pkg.sv
package vsel_pkg;
  localparam int unsigned RND_W = 32;

  // constant multiply modulo 2^RND_W built from shifts and adds only
  function automatic logic [RND_W-1:0] const_mul(input logic [RND_W-1:0] s,
                                                 input logic [RND_W-1:0] k);
    logic [RND_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < RND_W; i++) begin
      if (k[i]) acc = acc + (s << i);
    end
    return acc;
  endfunction
endpackage

// File: rtl/vsel_rr_counter.sv
module vsel_rr_counter #(
  parameter int unsigned WAY_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  output logic [WAY_W-1:0] cnt_q,
  output logic [WAY_W-1:0] cnt_next
);
  assign cnt_next = cnt_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (step) cnt_q <= cnt_next;
  end
endmodule

// File: rtl/vsel_shx_rng.sv
module vsel_shx_rng
  import vsel_pkg::*;
#(
  parameter logic [RND_W-1:0] SEED     = 32'd44203,
  parameter logic [RND_W-1:0] MUL_A    = 32'd17,
  parameter logic [RND_W-1:0] MUL_B    = 32'd7,
  parameter int unsigned      PICK_LSB = 17,
  parameter int unsigned      PICK_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  output logic [RND_W-1:0]  state_q,
  output logic [PICK_W-1:0] pick
);
  logic [RND_W-1:0] state_next;

  always_comb begin
    state_next = state_q ^ const_mul(state_q, MUL_A) ^ const_mul(state_q, MUL_B);
  end

  assign pick = state_next[PICK_LSB +: PICK_W];

  always_ff @(posedge clk) begin
    if (rst)       state_q <= SEED;
    else if (step) state_q <= state_next;
  end
endmodule

// File: rtl/vsel_lock_merge.sv
module vsel_lock_merge #(
  parameter int unsigned WAY_W    = 2,
  parameter int unsigned LOCK_W   = 32,
  parameter int unsigned LOCK_BIT = 31
) (
  input  logic [WAY_W-1:0]  base_way,
  input  logic [LOCK_W-1:0] lock_word,
  output logic [WAY_W-1:0]  way_out
);
  logic             force_way;
  logic [WAY_W-1:0] lock_way;

  assign force_way = lock_word[LOCK_BIT];
  assign lock_way  = lock_word[WAY_W-1:0];

  always_comb begin
    if (force_way) way_out = lock_way;
    else           way_out = base_way | lock_way;
  end
endmodule

// File: rtl/cache_victim_sel.sv
module cache_victim_sel
  import vsel_pkg::*;
#(
  parameter int unsigned      WAYS     = 4,
  parameter int unsigned      LOCK_W   = 32,
  parameter int unsigned      LOCK_BIT = 31,
  parameter logic [RND_W-1:0] SEED     = 32'd44203,
  parameter int unsigned      PICK_LSB = 17,
  localparam int unsigned     WAY_W    = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fill_req,
  input  logic              rr_mode,
  input  logic [LOCK_W-1:0] lock_reg,
  output logic [WAY_W-1:0]  victim_way
);
  logic [WAY_W-1:0] rr_cnt_q;
  logic [WAY_W-1:0] rr_cnt_next;
  logic [RND_W-1:0] rnd_q;
  logic [WAY_W-1:0] rnd_pick;
  logic [WAY_W-1:0] base_way;
  logic             rr_step;
  logic             rnd_step;

  assign rr_step  = fill_req & rr_mode;
  assign rnd_step = fill_req & ~rr_mode;

  vsel_rr_counter #(.WAY_W(WAY_W)) u_rr (
    .clk      (clk),
    .rst      (rst),
    .step     (rr_step),
    .cnt_q    (rr_cnt_q),
    .cnt_next (rr_cnt_next)
  );

  vsel_shx_rng #(
    .SEED     (SEED),
    .PICK_LSB (PICK_LSB),
    .PICK_W   (WAY_W)
  ) u_rng (
    .clk     (clk),
    .rst     (rst),
    .step    (rnd_step),
    .state_q (rnd_q),
    .pick    (rnd_pick)
  );

  assign base_way = rr_mode ? rr_cnt_next : rnd_pick;

  vsel_lock_merge #(
    .WAY_W    (WAY_W),
    .LOCK_W   (LOCK_W),
    .LOCK_BIT (LOCK_BIT)
  ) u_lock (
    .base_way  (base_way),
    .lock_word (lock_reg),
    .way_out   (victim_way)
  );
endmodule

// File: rtl/vsel_checker.sv
module vsel_checker #(
  parameter int unsigned WAY_W    = 2,
  parameter int unsigned LOCK_W   = 32,
  parameter int unsigned LOCK_BIT = 31,
  parameter logic [31:0] SEED     = 32'd44203,
  parameter int unsigned PICK_LSB = 17
) (
  input logic              clk,
  input logic              rst,
  input logic              fill_req,
  input logic              rr_mode,
  input logic [LOCK_W-1:0] lock_reg,
  input logic [WAY_W-1:0]  victim_way,
  input logic [WAY_W-1:0]  rr_cnt,
  input logic [31:0]       rnd_state
);
  // R1: engines hold their reset values right after reset
  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rr_cnt == '0 && rnd_state == SEED));

  // R2: each rotating fill moves the counter by one, wrapping
  a_r2_rr_advance: assert property (@(posedge clk) disable iff (rst)
    (fill_req && rr_mode) |=> rr_cnt == WAY_W'($past(rr_cnt) + 1'b1));

  // R3: random-mode victim with empty lockdown matches the stored new state
  a_r3_rnd_pick: assert property (@(posedge clk) disable iff (rst)
    (fill_req && !rr_mode && lock_reg == '0) |=>
      rnd_state[PICK_LSB +: WAY_W] == $past(victim_way));

  // R4: forced way
  a_r4_force: assert property (@(posedge clk) disable iff (rst)
    (fill_req && lock_reg[LOCK_BIT]) |-> victim_way == lock_reg[WAY_W-1:0]);

  // R5: floor bits always present in the victim
  a_r5_floor: assert property (@(posedge clk) disable iff (rst)
    (fill_req && !lock_reg[LOCK_BIT]) |->
      (victim_way & lock_reg[WAY_W-1:0]) == lock_reg[WAY_W-1:0]);

  // R6: no fill, no movement; each engine idles in the other mode
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !fill_req |=> ($stable(rr_cnt) && $stable(rnd_state)));

  a_r6_rnd_hold_rr: assert property (@(posedge clk) disable iff (rst)
    (fill_req && rr_mode) |=> $stable(rnd_state));

  a_r6_rr_hold_rnd: assert property (@(posedge clk) disable iff (rst)
    (fill_req && !rr_mode) |=> $stable(rr_cnt));
endmodule

bind cache_victim_sel vsel_checker #(
  .WAY_W    (WAY_W),
  .LOCK_W   (LOCK_W),
  .LOCK_BIT (LOCK_BIT),
  .SEED     (SEED),
  .PICK_LSB (PICK_LSB)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .fill_req   (fill_req),
  .rr_mode    (rr_mode),
  .lock_reg   (lock_reg),
  .victim_way (victim_way),
  .rr_cnt     (rr_cnt_q),
  .rnd_state  (rnd_q)
);

// File: tb/cache_victim_sel_bench.sv
module cache_victim_sel_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fill_req = 1'b0;
  logic        rr_mode = 1'b0;
  logic [31:0] lock_reg = '0;
  logic [1:0]  victim_way;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [1:0]  m_cnt;
  logic [31:0] m_seed;

  always #4 clk = ~clk;

  cache_victim_sel u_cache_victim_sel (
    .clk        (clk),
    .rst        (rst),
    .fill_req   (fill_req),
    .rr_mode    (rr_mode),
    .lock_reg   (lock_reg),
    .victim_way (victim_way)
  );

  function automatic logic [31:0] rnd_next(input logic [31:0] s);
    return s ^ (s * 32'd17) ^ (s * 32'd7);
  endfunction

  task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst = 1'b1; fill_req = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    m_cnt = '0; m_seed = 32'd44203;
  endtask

  // one cycle: drive at falling edge, sample shortly after (before the rising edge)
  task automatic step(input bit req, input bit mode, input logic [31:0] lk, input string tag);
    logic [1:0] base;
    logic [1:0] exp;
    @(negedge clk);
    fill_req = req; rr_mode = mode; lock_reg = lk;
    #1;
    if (req) begin
      if (mode) begin
        m_cnt = m_cnt + 2'd1;
        base  = m_cnt;
      end else begin
        m_seed = rnd_next(m_seed);
        base   = m_seed[18:17];
      end
      exp = lk[31] ? lk[1:0] : (base | lk[1:0]);
      check(tag, victim_way, exp);
    end
  endtask

  function automatic logic [31:0] rand_lock();
    logic [31:0] v;
    v = $urandom;
    case ($urandom % 4)
      0: v = 32'h0;
      1: v = v & 32'h7FFF_FFFC;
      2: v = v & 32'h7FFF_FFFF;
      default: v = v | 32'h8000_0000;
    endcase
    return v;
  endfunction

  initial begin
    void'($urandom(32'd1234));
    m_cnt = '0; m_seed = 32'd44203;

    // R1: reset values seen through the first fill in each mode
    apply_reset();
    step(1, 1, 32'h0, "R1 first rotating fill");
    apply_reset();
    step(1, 0, 32'h0, "R1 first random fill");

    // R2: rotating wrap with no lockdown
    apply_reset();
    for (int i = 0; i < 8; i++) step(1, 1, 32'h0, "R2 rotating sequence");

    // R3: long random run, lockdown empty, occasional idle cycles (R6)
    for (int i = 0; i < 700; i++) begin
      if ($urandom % 5 == 0) step(0, $urandom % 2, $urandom, "R6 idle");
      step(1, 0, 32'h0, "R3 random sequence");
    end

    // R4: forced ways with random upper bits (R8)
    for (int i = 0; i < 4; i++) begin
      step(1, 1, 32'hFFFF_FFFC | i, "R4 forced rotating");
      step(1, 0, 32'h8000_0000 | i, "R4 forced random");
    end

    // R5 / R8: floor with junk in bits 30:2
    for (int i = 0; i < 40; i++)
      step(1, i % 2, ($urandom & 32'h7FFF_FFFC) | (i % 4), "R5 floor R8 junk");

    // R7 and R6: mode switching between fills, idle cycles in between
    for (int i = 0; i < 600; i++) begin
      if ($urandom % 3 == 0) step(0, $urandom % 2, rand_lock(), "R6 idle");
      step(1, $urandom % 2, rand_lock(), "R7 mixed fill");
    end

    // R1 again after mid-run reset
    apply_reset();
    step(1, 0, 32'h0, "R1 random after reset");
    step(1, 1, 32'h0, "R1 rotating after reset");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL R7 watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule